// File: doc/BRIEF.md
# CGMS Type A Line Inserter

This block places a 20-bit copy-generation word on one chosen line of the vertical blanking interval. A line counter, a field flag and a video-standard code select the insertion line. When that line is current, the enable is set and the start-of-data strobe arrives, the block emits a one-bit-long reference pulse at level 1. It then sends the 20 word bits as plain digital levels, each held for `BIT_CLKS` clocks. Analog shaping and conversion happen downstream.

The word comes from a 20-bit register input. With the CRC option off, all 20 bits go out unchanged. With it on, the upper six bits are replaced by a CRC-6 that the block builds serially over the lower fourteen bits while those bits are being sent. The register word and the CRC option are captured when the window opens. Nothing at the inputs can disturb a window once it has started.

The controller has three states. `S_IDLE` moves to `S_REF` on a launch, meaning the strobe, the enable and a line match in the same cycle. `S_REF` moves to `S_DATA` after `BIT_CLKS` clocks. `S_DATA` returns to `S_IDLE` after the last clock of bit 19.

Top module: `cgms_line_inserter`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_bit` and `busy` are 0.
- R2: With `std_sel`=0 (NTSC interlaced), a window opens on line 20 when `field_odd`=1 and `field_sel[0]`=1, or on line 283 when `field_odd`=0 and `field_sel[1]`=1. No other combination opens one.
- R3: For `std_sel`=1 (525p) the line is 41, for 2 (625p) it is 43 and for 3 (720p) it is 24. `field_odd` and `field_sel` have no effect in these standards.
- R4: For `std_sel`=4 (1080i) a window opens on line 19 or on line 582, whatever the field flag.
- R5: `std_sel` codes 5 to 7, `ins_en`=0, or a line that does not match each stop a window from opening.
- R6: A window opens on the clock edge that samples `data_start`=1 together with a match. `busy` then stays high for exactly 21×`BIT_CLKS` cycles, and the first `BIT_CLKS` of them carry the reference level 1.
- R7: After the reference pulse, bits C0 to C19 follow in that order, each for `BIT_CLKS` cycles.
- R8: With `crc_en`=1, C0–C13 come from `reg_word[13:0]`. The CRC register g[5:0] is preset to all ones. For each bit d of C0..C13, taken in order, f = d XOR g[5], then g becomes {g[4:0], f} with bit 1 additionally XORed by f. This implements x^6+x+1. C(14+k) = g[k] for k = 0..5.
- R9: With `crc_en`=0, bit Ci equals `reg_word[i]` for all 20 bits.
- R10: `out_bit` is 0 whenever `busy` is 0.
- R11: `reg_word` and `crc_en` are captured at the opening edge. Later changes to them, and further strobes during a window, do not affect that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_num | input | LINE_W | Current line number |
| field_odd | input | 1 | 1 in an odd field, 0 in an even field |
| std_sel | input | 3 | Video standard code (0 NTSC, 1 525p, 2 625p, 3 720p, 4 1080i) |
| field_sel | input | 2 | NTSC field enable: bit 0 odd, bit 1 even |
| ins_en | input | 1 | Insertion enable |
| crc_en | input | 1 | Replace C19..C14 by the on-chip CRC-6 |
| reg_word | input | 20 | Register word, bit i is Ci |
| data_start | input | 1 | Start-of-data strobe within the line |
| out_bit | output | 1 | Serial digital level |
| busy | output | 1 | High during the reference pulse and the data bits |

## Verification
The hardest situation to reach from the ports is a window disturbed midway. This means a second strobe, together with a new register word and a flipped CRC option, arriving while the CRC-6 is still being accumulated. The stimulus opens a window and lets a few data bits pass. It then changes those inputs and pulses the strobe again while the payload is still going out. The bench model keeps comparing every cycle against the captured word. The NTSC field gating is reached by sweeping field flag, field-select and line combinations, including lines that belong to the other field.

// File: rtl/cgms_pkg.sv
package cgms_pkg;
    localparam int WORD_BITS = 20;
    localparam int CRC_BITS  = 6;
    localparam int PAY_BITS  = WORD_BITS - CRC_BITS;

    localparam logic [2:0] STD_NTSC  = 3'd0;
    localparam logic [2:0] STD_525P  = 3'd1;
    localparam logic [2:0] STD_625P  = 3'd2;
    localparam logic [2:0] STD_720P  = 3'd3;
    localparam logic [2:0] STD_1080I = 3'd4;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REF  = 2'd1,
        S_DATA = 2'd2
    } ins_state_e;
endpackage

// File: rtl/cgms_line_match.sv
module cgms_line_match #(
    parameter int LINE_W = 11
) (
    input  logic [LINE_W-1:0] line_num,
    input  logic              field_odd,
    input  logic [2:0]        std_sel,
    input  logic [1:0]        field_sel,
    output logic              hit
);
    import cgms_pkg::*;

    function automatic logic is_line(input logic [LINE_W-1:0] l, input int n);
        return l == LINE_W'(n);
    endfunction

    always_comb begin
        unique case (std_sel)
            STD_NTSC:  hit = (field_odd  && field_sel[0] && is_line(line_num, 20)) ||
                             (!field_odd && field_sel[1] && is_line(line_num, 283));
            STD_525P:  hit = is_line(line_num, 41);
            STD_625P:  hit = is_line(line_num, 43);
            STD_720P:  hit = is_line(line_num, 24);
            STD_1080I: hit = is_line(line_num, 19) || is_line(line_num, 582);
            default:   hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/cgms_crc6_step.sv
module cgms_crc6_step (
    input  logic [5:0] cur,
    input  logic       din,
    output logic [5:0] nxt
);
    logic fb;
    always_comb begin
        fb  = din ^ cur[5];
        nxt = {cur[4:0], fb} ^ {4'b0000, fb, 1'b0};
    end
endmodule

// File: rtl/cgms_bit_timer.sv
module cgms_bit_timer #(
    parameter int BIT_CLKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int CNT_W = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;

    logic [CNT_W-1:0] cnt;

    assign last = (cnt == CNT_W'(BIT_CLKS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || last)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cgms_line_inserter.sv
module cgms_line_inserter
    import cgms_pkg::*;
#(
    parameter int LINE_W   = 11,
    parameter int BIT_CLKS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] line_num,
    input  logic              field_odd,
    input  logic [2:0]        std_sel,
    input  logic [1:0]        field_sel,
    input  logic              ins_en,
    input  logic              crc_en,
    input  logic [19:0]       reg_word,
    input  logic              data_start,
    output logic              out_bit,
    output logic              busy
);
    localparam int IDX_W = $clog2(WORD_BITS);

    ins_state_e            state;
    logic [IDX_W-1:0]      bit_idx;
    logic [WORD_BITS-1:0]  word_q;
    logic                  crc_on_q;
    logic [CRC_BITS-1:0]   crc_q;
    logic [CRC_BITS-1:0]   crc_nxt;
    logic                  line_hit;
    logic                  bit_last;
    logic                  launch;
    logic                  in_crc;
    logic [IDX_W-1:0]      crc_off;

    cgms_line_match #(.LINE_W(LINE_W)) u_match (
        .line_num  (line_num),
        .field_odd (field_odd),
        .std_sel   (std_sel),
        .field_sel (field_sel),
        .hit       (line_hit)
    );

    cgms_bit_timer #(.BIT_CLKS(BIT_CLKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state != S_IDLE),
        .last  (bit_last)
    );

    cgms_crc6_step u_crc (
        .cur (crc_q),
        .din (word_q[bit_idx]),
        .nxt (crc_nxt)
    );

    assign launch  = data_start && ins_en && line_hit;
    assign in_crc  = crc_on_q && (bit_idx >= IDX_W'(PAY_BITS));
    assign crc_off = bit_idx - IDX_W'(PAY_BITS);

    // state register and captured window context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            bit_idx  <= '0;
            word_q   <= '0;
            crc_on_q <= 1'b0;
            crc_q    <= '1;
        end else begin
            unique case (state)
                S_IDLE: if (launch) begin
                    state    <= S_REF;
                    bit_idx  <= '0;
                    word_q   <= reg_word;
                    crc_on_q <= crc_en;
                    crc_q    <= '1;
                end
                S_REF: if (bit_last) state <= S_DATA;
                S_DATA: if (bit_last) begin
                    if (crc_on_q && (bit_idx < IDX_W'(PAY_BITS)))
                        crc_q <= crc_nxt;
                    if (bit_idx == IDX_W'(WORD_BITS - 1))
                        state <= S_IDLE;
                    else
                        bit_idx <= bit_idx + 1'b1;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            S_REF: begin
                out_bit = 1'b1;
                busy    = 1'b1;
            end
            S_DATA: begin
                out_bit = in_crc ? crc_q[crc_off[2:0]] : word_q[bit_idx];
                busy    = 1'b1;
            end
            default: begin
                out_bit = 1'b0;
                busy    = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/cgms_line_inserter_chk.sv
module cgms_line_inserter_chk #(
    parameter int BIT_CLKS = 8
) (
    input logic clk,
    input logic rst_n,
    input logic data_start,
    input logic ins_en,
    input logic out_bit,
    input logic busy
);
    localparam int WIN = 21 * BIT_CLKS;
    localparam int LW  = $clog2(WIN + 2);

    logic [LW-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_len <= '0;
        else if (!busy)
            run_len <= '0;
        else
            run_len <= run_len + 1'b1;
    end

    // R10
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !out_bit);

    // R6
    ref_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> out_bit);

    // R6
    open_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(data_start));

    // R5
    open_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ins_en));

    // R6
    window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == LW'(WIN)));
endmodule

bind cgms_line_inserter cgms_line_inserter_chk #(.BIT_CLKS(BIT_CLKS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .data_start (data_start),
    .ins_en     (ins_en),
    .out_bit    (out_bit),
    .busy       (busy)
);

// File: tb/cgms_line_inserter_test.sv
module cgms_line_inserter_test;
    localparam int LW = 11;
    localparam int BC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [LW-1:0] line_num = '0;
    logic          field_odd = 1'b0;
    logic [2:0]    std_sel = '0;
    logic [1:0]    field_sel = '0;
    logic          ins_en = 1'b0;
    logic          crc_en = 1'b0;
    logic [19:0]   reg_word = '0;
    logic          data_start = 1'b0;
    logic          out_bit;
    logic          busy;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done = 0;

    bit    mq[$];
    bit    exp_bit = 0;
    bit    exp_busy = 0;
    bit    busy_seen = 0;

    always #10 clk = ~clk;

    cgms_line_inserter #(.LINE_W(LW), .BIT_CLKS(BC)) uut (
        .clk(clk), .rst_n(rst_n), .line_num(line_num), .field_odd(field_odd),
        .std_sel(std_sel), .field_sel(field_sel), .ins_en(ins_en), .crc_en(crc_en),
        .reg_word(reg_word), .data_start(data_start), .out_bit(out_bit), .busy(busy)
    );

    function automatic bit want_line(int s, int ln, bit odd, logic [1:0] fs);
        case (s)
            0: return (odd && fs[0] && ln == 20) || (!odd && fs[1] && ln == 283);
            1: return ln == 41;
            2: return ln == 43;
            3: return ln == 24;
            4: return ln == 19 || ln == 582;
            default: return 0;
        endcase
    endfunction

    function automatic logic [19:0] full_word(logic [19:0] w, bit crc);
        logic [5:0] g;
        logic [19:0] r;
        bit f;
        if (!crc) return w;
        g = 6'h3F;
        for (int i = 0; i < 14; i++) begin
            f = w[i] ^ g[5];
            g = {g[4:0], f};
            if (f) g[1] = ~g[1];
        end
        r = w;
        for (int k = 0; k < 6; k++) r[14 + k] = g[k];
        return r;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            exp_bit = 0;
            exp_busy = 0;
        end else if (mq.size() > 0) begin
            exp_bit = mq.pop_front();
            exp_busy = 1;
        end else if (exp_busy) begin
            exp_bit = 0;
            exp_busy = 0;
        end else if (data_start && ins_en &&
                     want_line(int'(std_sel), int'(line_num), field_odd, field_sel)) begin
            logic [19:0] fw;
            fw = full_word(reg_word, crc_en);
            for (int c = 0; c < BC; c++) mq.push_back(1'b1);
            for (int i = 0; i < 20; i++)
                for (int c = 0; c < BC; c++) mq.push_back(fw[i]);
            exp_bit = mq.pop_front();
            exp_busy = 1;
        end else begin
            exp_bit = 0;
            exp_busy = 0;
        end
    end

    // per-cycle comparison, away from the edge
    always @(posedge clk) begin
        #5;
        if (busy) busy_seen = 1;
        check(busy === exp_busy, {cur_req, " busy R6/R10"}, int'(busy), int'(exp_busy));
        check(out_bit === exp_bit, {cur_req, " out_bit R6/R7/R10"}, int'(out_bit), int'(exp_bit));
    end

    task automatic run_line(int s, int ln, bit odd, logic [1:0] fs, bit en,
                            bit crc, logic [19:0] w, string req);
        cur_req = req;
        @(negedge clk);
        std_sel = 3'(s); line_num = LW'(ln); field_odd = odd; field_sel = fs;
        ins_en = en; crc_en = crc; reg_word = w; data_start = 1'b1;
        busy_seen = 0;
        @(negedge clk);
        data_start = 1'b0;
        repeat (21 * BC + 3) @(negedge clk);
        check(busy_seen == (en && want_line(s, ln, odd, fs)), {req, " window opened"},
              int'(busy_seen), int'(en && want_line(s, ln, odd, fs)));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check(out_bit === 1'b0, "R1 out in reset", int'(out_bit), 0);
        check(busy === 1'b0, "R1 busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0, "R1 busy after reset", int'(busy), 0);

        // R2 NTSC field gating
        run_line(0, 20, 1, 2'b01, 1, 0, 20'hA5C3E, "R2");
        run_line(0, 283, 0, 2'b10, 1, 0, 20'h5A3C1, "R2");
        run_line(0, 20, 1, 2'b10, 1, 0, 20'hFFFFF, "R2");
        run_line(0, 283, 0, 2'b01, 1, 0, 20'hFFFFF, "R2");
        run_line(0, 283, 1, 2'b11, 1, 0, 20'hFFFFF, "R2");
        run_line(0, 20, 1, 2'b00, 1, 0, 20'hFFFFF, "R2");
        run_line(0, 20, 0, 2'b11, 1, 0, 20'hFFFFF, "R2");
        // R3 progressive
        run_line(1, 41, 0, 2'b00, 1, 0, 20'h12345, "R3");
        run_line(2, 43, 1, 2'b00, 1, 0, 20'h0F0F0, "R3");
        run_line(3, 24, 0, 2'b00, 1, 0, 20'hC0FFE, "R3");
        run_line(3, 41, 0, 2'b11, 1, 0, 20'hFFFFF, "R3");
        // R4 1080i
        run_line(4, 19, 1, 2'b00, 1, 0, 20'h00001, "R4");
        run_line(4, 582, 0, 2'b00, 1, 0, 20'h80000, "R4");
        run_line(4, 20, 1, 2'b11, 1, 0, 20'hFFFFF, "R4");
        // R5 suppression
        run_line(5, 20, 1, 2'b11, 1, 0, 20'hFFFFF, "R5");
        run_line(7, 24, 1, 2'b11, 1, 0, 20'hFFFFF, "R5");
        run_line(1, 41, 0, 2'b11, 0, 0, 20'hFFFFF, "R5");
        run_line(2, 41, 0, 2'b11, 1, 0, 20'hFFFFF, "R5");
        // R8 CRC on
        run_line(0, 20, 1, 2'b11, 1, 1, 20'h00000, "R8");
        run_line(1, 41, 0, 2'b00, 1, 1, 20'h03FFF, "R8");
        run_line(3, 24, 0, 2'b00, 1, 1, 20'hFC2A5, "R8");
        run_line(4, 582, 0, 2'b00, 1, 1, 20'h01234, "R8");
        // R9 CRC off, upper bits raw; R7 order
        run_line(2, 43, 0, 2'b00, 1, 0, 20'hFC000, "R9");
        run_line(1, 41, 0, 2'b00, 1, 0, 20'h00001, "R7");

        // R11 inputs disturbed during a window
        cur_req = "R11";
        @(negedge clk);
        std_sel = 3'd1; line_num = LW'(41); ins_en = 1; crc_en = 1;
        reg_word = 20'h1B3D5; data_start = 1'b1; busy_seen = 0;
        @(negedge clk);
        data_start = 1'b0;
        repeat (3 * BC + 1) @(negedge clk);
        reg_word = 20'hE4C2A; crc_en = 0; data_start = 1'b1;
        @(negedge clk);
        data_start = 1'b0;
        repeat (21 * BC) @(negedge clk);
        check(busy === 1'b0, "R11 window ended on time", int'(busy), 0);
        check(busy_seen == 1'b1, "R11 window opened", int'(busy_seen), 1);

        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule